// File: doc/BRIEF.md
# Protected Output Channel Controller

This block is the digital control for one switched output channel, such as a high-side switch or a relay coil driver. Software gives it a channel enable and an on/off command. The external driver reports three fault conditions on separate wires: open load, overcurrent and overtemperature. From these inputs the block drives a single gate signal.

The gate signal has a defined default in each of three situations. After reset it is off. While the supply-loss input is high it is forced off. After a qualified fault it goes off and then follows a chosen policy. Under the latch-off policy the channel stays dark until software clears the fault. Under the retry policy the channel cools down for a programmed interval and then switches on again. After a programmed number of consecutive retries, the retry policy falls back to latch-off.

The overcurrent and open-load reports are ignored for a programmable blanking interval after each turn-on, so that inrush current and a load that is still settling do not trip the channel. Each fault cause keeps its own sticky status bit and its own saturating event counter. These remain readable after the fault has gone away, and a single clear command resets all of them.

Top module: `out_chan_ctrl`

## Requirements
- R1: After reset `drive_out` is 0, all status bits are 0 and all counters are 0. `drive_out` rises only on the cycle after a clock edge at which `cfg_enable` and `cmd_on` were both 1 and `supply_lost` was 0.
- R2: While `supply_lost` is 1, `drive_out` is 0 in that same cycle, without waiting for a clock edge. At the next clock edge the channel returns to its off state. It turns on again only when a later edge sees the command with the supply present.
- R3: A fault is qualified only while the output is actually driving. When a fault is qualified, its cause is recorded in `sticky_status`: bit 0 for open load, bit 1 for overcurrent, bit 2 for thermal. A recorded bit stays set after the fault input returns low, and only `fault_clear` resets it.
- R4: With `cfg_latch_mode`=1, a qualified fault switches `drive_out` off at the next clock edge and sets `latched_off`. The output then stays off, whatever the command does, until an edge that samples `fault_clear`=1. The channel is then off but no longer latched, and it turns on again one edge later if it is still commanded.
- R5: With `cfg_latch_mode`=0, a qualified fault switches the output off for exactly `cfg_cooldown`+1 cycles. The channel then turns on again if it is still commanded. If the command is withdrawn, or the supply is lost, during the cooldown, the channel goes to off.
- R6: In retry mode, a qualified fault that arrives after `cfg_max_retry` consecutive retries latches the channel, exactly as in R4. The retry count returns to zero whenever the channel passes through off and whenever `fault_clear` is sampled.
- R7: The overcurrent input is ignored during the first `cfg_blank` cycles of each on period. It is qualified from the following cycle onwards. The thermal input is qualified in every cycle in which the output is driving.
- R8: The open-load input is ignored during the same blanking interval and is qualified after it. All three fault inputs have no effect while the output is not driving.
- R9: Each cause has its own counter (`cnt_open`, `cnt_ocur`, `cnt_temp`) that adds one per qualified fault and saturates at 2^CNT_W-1. Sampling `fault_clear` zeroes all counters and status bits. If a fault is qualified on the same edge as the clear, that fault leaves its counter at 1 and its status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Channel enable |
| cmd_on | input | 1 | Software on/off command |
| supply_lost | input | 1 | Supply-loss indication; forces the output off |
| flt_open | input | 1 | Open-load report from the driver |
| flt_ocur | input | 1 | Overcurrent report from the driver |
| flt_temp | input | 1 | Overtemperature report from the driver |
| cfg_latch_mode | input | 1 | 1 selects latch-off, 0 selects retry |
| cfg_cooldown | input | TW | Cooldown length, in cycles, minus one |
| cfg_max_retry | input | RW | Number of consecutive retries allowed before latching |
| cfg_blank | input | TW | Blanking cycles after turn-on |
| fault_clear | input | 1 | Clears status, counters, retry count and the latch |
| drive_out | output | 1 | Gate or drive signal |
| latched_off | output | 1 | Channel is latched off |
| sticky_status | output | 3 | Sticky cause bits: open, overcurrent, thermal |
| cnt_open | output | CNT_W | Open-load event counter |
| cnt_ocur | output | CNT_W | Overcurrent event counter |
| cnt_temp | output | CNT_W | Thermal event counter |

## Verification
The hardest situation to reach from the ports is the escalation from retry to latch-off. That path needs a chain of consecutive faults, each separated by a full cooldown, and no pass through off in between. The stimulus holds the thermal input high with a short cooldown, so the channel cycles on and off by itself until the retry budget runs out. A narrow counter width lets the same loop also drive a counter into saturation. Blanking is reached by asserting the overcurrent or open-load input at the moment of turn-on and checking on the exact cycle where the blanking window ends.

// File: rtl/out_chan_pkg.sv
package out_chan_pkg;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_ON    = 2'd1,
    CH_COOL  = 2'd2,
    CH_LATCH = 2'd3
  } ch_state_e;

  localparam int CAUSE_OPEN = 0;
  localparam int CAUSE_OCUR = 1;
  localparam int CAUSE_TEMP = 2;
  localparam int N_CAUSE    = 3;

  // Increment v by one when en is set, but never past lim.
  function automatic logic [31:0] sat_step(input logic [31:0] v,
                                           input logic [31:0] lim,
                                           input logic en);
    return (en && (v < lim)) ? v + 32'd1 : v;
  endfunction

  // A fault leads to latch-off when the policy says so or the retry budget is used up.
  function automatic logic must_latch(input logic latch_mode,
                                      input logic [31:0] retries,
                                      input logic [31:0] budget);
    return latch_mode || (retries >= budget);
  endfunction

endpackage

// File: rtl/out_chan_satcnt.sv
module out_chan_satcnt
  import out_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= inc ? W'(1) : '0;
    else          cnt <= W'(sat_step(32'(cnt), 32'(CMAX), inc));
  end

endmodule

// File: rtl/out_chan_evidence.sv
module out_chan_evidence
  import out_chan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic [N_CAUSE-1:0]              hit,
  output logic [N_CAUSE-1:0]              sticky,
  output logic [N_CAUSE-1:0][CNT_W-1:0]   counts
);

  for (genvar gi = 0; gi < N_CAUSE; gi++) begin : g_cause
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (clr) flag_q <= hit[gi];
      else          flag_q <= flag_q | hit[gi];
    end

    assign sticky[gi] = flag_q;

    out_chan_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (hit[gi]),
      .cnt   (counts[gi])
    );
  end

endmodule

// File: rtl/out_chan_fsm.sv
module out_chan_fsm
  import out_chan_pkg::*;
#(
  parameter int TW = 16,
  parameter int RW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               want,
  input  logic               supply_lost,
  input  logic               fault_clear,
  input  logic               latch_mode,
  input  logic [TW-1:0]      cfg_cooldown,
  input  logic [RW-1:0]      cfg_max_retry,
  input  logic [TW-1:0]      cfg_blank,
  input  logic [N_CAUSE-1:0] flt_raw,
  output ch_state_e          state,
  output logic [N_CAUSE-1:0] hit,
  output logic               blank_done
);

  ch_state_e     state_q, state_d;
  logic [TW-1:0] on_timer;
  logic [TW-1:0] cool_cnt;
  logic [RW-1:0] retry_cnt;
  logic          live;
  logic          any_hit;
  logic          go_latch;
  logic          cool_done;

  assign live       = (state_q == CH_ON) && !supply_lost;
  assign blank_done = on_timer >= cfg_blank;
  assign cool_done  = cool_cnt >= cfg_cooldown;

  assign hit[CAUSE_OPEN] = live && blank_done && flt_raw[CAUSE_OPEN];
  assign hit[CAUSE_OCUR] = live && blank_done && flt_raw[CAUSE_OCUR];
  assign hit[CAUSE_TEMP] = live && flt_raw[CAUSE_TEMP];
  assign any_hit         = |hit;
  assign go_latch        = must_latch(latch_mode, 32'(retry_cnt), 32'(cfg_max_retry));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CH_OFF:   if (want) state_d = CH_ON;
      CH_ON: begin
        if (any_hit)    state_d = go_latch ? CH_LATCH : CH_COOL;
        else if (!want) state_d = CH_OFF;
      end
      CH_COOL: begin
        if (!want)          state_d = CH_OFF;
        else if (cool_done) state_d = CH_ON;
      end
      CH_LATCH: if (fault_clear) state_d = CH_OFF;
      default:  state_d = CH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 on_timer <= '0;
    else if (state_q != CH_ON)  on_timer <= '0;
    else                        on_timer <= TW'(sat_step(32'(on_timer), 32'(cfg_blank), 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cool_cnt <= '0;
    else if (state_q != CH_COOL) cool_cnt <= '0;
    else                         cool_cnt <= TW'(sat_step(32'(cool_cnt), 32'(cfg_cooldown), 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  retry_cnt <= '0;
    else if (fault_clear || state_q == CH_OFF)   retry_cnt <= '0;
    else if (state_q == CH_ON && any_hit && !go_latch)
      retry_cnt <= retry_cnt + RW'(1);
  end

  assign state = state_q;

endmodule

// File: rtl/out_chan_ctrl.sv
module out_chan_ctrl
  import out_chan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TW    = 16,
  parameter int RW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cmd_on,
  input  logic             supply_lost,
  input  logic             flt_open,
  input  logic             flt_ocur,
  input  logic             flt_temp,
  input  logic             cfg_latch_mode,
  input  logic [TW-1:0]    cfg_cooldown,
  input  logic [RW-1:0]    cfg_max_retry,
  input  logic [TW-1:0]    cfg_blank,
  input  logic             fault_clear,
  output logic             drive_out,
  output logic             latched_off,
  output logic [2:0]       sticky_status,
  output logic [CNT_W-1:0] cnt_open,
  output logic [CNT_W-1:0] cnt_ocur,
  output logic [CNT_W-1:0] cnt_temp
);

  logic                          want;
  logic [N_CAUSE-1:0]            flt_raw;
  logic [N_CAUSE-1:0]            fault_hit;
  logic [N_CAUSE-1:0][CNT_W-1:0] cause_cnt;
  logic                          blank_done;
  ch_state_e                     ch_state;

  assign want = cfg_enable && cmd_on && !supply_lost;

  assign flt_raw[CAUSE_OPEN] = flt_open;
  assign flt_raw[CAUSE_OCUR] = flt_ocur;
  assign flt_raw[CAUSE_TEMP] = flt_temp;

  out_chan_fsm #(.TW(TW), .RW(RW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .want          (want),
    .supply_lost   (supply_lost),
    .fault_clear   (fault_clear),
    .latch_mode    (cfg_latch_mode),
    .cfg_cooldown  (cfg_cooldown),
    .cfg_max_retry (cfg_max_retry),
    .cfg_blank     (cfg_blank),
    .flt_raw       (flt_raw),
    .state         (ch_state),
    .hit           (fault_hit),
    .blank_done    (blank_done)
  );

  out_chan_evidence #(.CNT_W(CNT_W)) u_evd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fault_clear),
    .hit    (fault_hit),
    .sticky (sticky_status),
    .counts (cause_cnt)
  );

  // Supply loss gates the drive combinationally: no clock edge is needed to go safe.
  assign drive_out   = (ch_state == CH_ON) && !supply_lost;
  assign latched_off = (ch_state == CH_LATCH);
  assign cnt_open    = cause_cnt[CAUSE_OPEN];
  assign cnt_ocur    = cause_cnt[CAUSE_OCUR];
  assign cnt_temp    = cause_cnt[CAUSE_TEMP];

endmodule

// File: rtl/out_chan_ctrl_chk.sv
module out_chan_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             cmd_on,
  input logic             supply_lost,
  input logic             fault_clear,
  input logic             drive_out,
  input logic             latched_off,
  input logic [2:0]       sticky_status,
  input logic [2:0]       fault_hit,
  input logic [CNT_W-1:0] cnt_open,
  input logic [CNT_W-1:0] cnt_ocur,
  input logic [CNT_W-1:0] cnt_temp
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_SUPPLY_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    supply_lost |-> !drive_out); // R2

  AST_ON_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_out) |-> $past(cfg_enable && cmd_on)); // R1

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_off && !fault_clear) |=> latched_off); // R4

  AST_LATCH_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> !drive_out); // R4

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_clear |=> ((sticky_status & $past(sticky_status)) == $past(sticky_status))); // R3

  AST_HIT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_hit) |=> ((sticky_status & $past(fault_hit)) == $past(fault_hit))); // R3

  AST_HIT_DARKENS: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_hit) |=> !drive_out); // R5

  AST_SAT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_open == CMAX && !fault_clear) |=> cnt_open == CMAX); // R9

  AST_SAT_OCUR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ocur == CMAX && !fault_clear) |=> cnt_ocur == CMAX); // R9

  AST_SAT_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_temp == CMAX && !fault_clear) |=> cnt_temp == CMAX); // R9

endmodule

bind out_chan_ctrl out_chan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cmd_on        (cmd_on),
  .supply_lost   (supply_lost),
  .fault_clear   (fault_clear),
  .drive_out     (drive_out),
  .latched_off   (latched_off),
  .sticky_status (sticky_status),
  .fault_hit     (fault_hit),
  .cnt_open      (cnt_open),
  .cnt_ocur      (cnt_ocur),
  .cnt_temp      (cnt_temp)
);

// File: tb/out_chan_ctrl_tb.sv
`timescale 1ns/100ps
module out_chan_ctrl_tb;

  localparam int CNT_W = 3;
  localparam int TW    = 8;
  localparam int RW    = 4;
  localparam int CMAXI = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cmd_on = 0, supply_lost = 0;
  logic flt_open = 0, flt_ocur = 0, flt_temp = 0;
  logic cfg_latch_mode = 0, fault_clear = 0;
  logic [TW-1:0] cfg_cooldown = 0, cfg_blank = 0;
  logic [RW-1:0] cfg_max_retry = 0;
  logic drive_out, latched_off;
  logic [2:0] sticky_status;
  logic [CNT_W-1:0] cnt_open, cnt_ocur, cnt_temp;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  out_chan_ctrl #(.CNT_W(CNT_W), .TW(TW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cmd_on(cmd_on),
    .supply_lost(supply_lost), .flt_open(flt_open), .flt_ocur(flt_ocur),
    .flt_temp(flt_temp), .cfg_latch_mode(cfg_latch_mode),
    .cfg_cooldown(cfg_cooldown), .cfg_max_retry(cfg_max_retry),
    .cfg_blank(cfg_blank), .fault_clear(fault_clear), .drive_out(drive_out),
    .latched_off(latched_off), .sticky_status(sticky_status),
    .cnt_open(cnt_open), .cnt_ocur(cnt_ocur), .cnt_temp(cnt_temp)
  );

  // Behavioural reference: 0 off, 1 driving, 2 cooling, 3 latched
  int m_st = 0, m_ont = 0, m_cool = 0, m_ret = 0;
  int m_stk[3] = '{0, 0, 0};
  int m_cnt[3] = '{0, 0, 0};
  int nst, nret;
  bit h[3];
  bit wantv, anyh, latch_now;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ont = 0; m_cool = 0; m_ret = 0;
      foreach (m_stk[i]) begin m_stk[i] = 0; m_cnt[i] = 0; end
    end else begin
      wantv = cfg_enable && cmd_on && !supply_lost;
      h[0] = (m_st == 1) && !supply_lost && (m_ont >= int'(cfg_blank)) && flt_open;
      h[1] = (m_st == 1) && !supply_lost && (m_ont >= int'(cfg_blank)) && flt_ocur;
      h[2] = (m_st == 1) && !supply_lost && flt_temp;
      anyh = h[0] || h[1] || h[2];
      latch_now = cfg_latch_mode || (m_ret >= int'(cfg_max_retry));
      for (int i = 0; i < 3; i++) begin
        if (fault_clear) begin
          m_stk[i] = h[i]; m_cnt[i] = h[i];
        end else if (h[i]) begin
          m_stk[i] = 1;
          if (m_cnt[i] < CMAXI) m_cnt[i] = m_cnt[i] + 1;
        end
      end
      nst = m_st;
      if (m_st == 0 && wantv) nst = 1;
      else if (m_st == 1) begin
        if (anyh) nst = latch_now ? 3 : 2;
        else if (!wantv) nst = 0;
      end else if (m_st == 2) begin
        if (!wantv) nst = 0;
        else if (m_cool >= int'(cfg_cooldown)) nst = 1;
      end else if (m_st == 3 && fault_clear) nst = 0;
      nret = m_ret;
      if (fault_clear || m_st == 0) nret = 0;
      else if (m_st == 1 && anyh && !latch_now) nret = m_ret + 1;
      if (m_st != 1) m_ont = 0; else if (m_ont < int'(cfg_blank)) m_ont = m_ont + 1;
      if (m_st != 2) m_cool = 0; else if (m_cool < int'(cfg_cooldown)) m_cool = m_cool + 1;
      m_st = nst; m_ret = nret;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the reference away from the active edge, every cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 drive_out vs model", int'(drive_out), int'((m_st == 1) && !supply_lost));
      chk("R4 latched_off vs model", int'(latched_off), int'(m_st == 3));
      chk("R3 sticky_status vs model", int'(sticky_status), m_stk[0] + 2*m_stk[1] + 4*m_stk[2]);
      chk("R9 cnt_open vs model", int'(cnt_open), m_cnt[0]);
      chk("R9 cnt_ocur vs model", int'(cnt_ocur), m_cnt[1]);
      chk("R9 cnt_temp vs model", int'(cnt_temp), m_cnt[2]);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cfg_cooldown = 2; cfg_max_retry = 1; cfg_blank = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset drive", int'(drive_out), 0);
    chk("R1 reset status", int'(sticky_status), 0);
    chk("R1 reset counter", int'(cnt_temp), 0);

    cmd_on = 1; step(4);
    chk("R1 command without enable", int'(drive_out), 0);
    cfg_enable = 1; step(1);
    chk("R1 enable and command", int'(drive_out), 1);

    supply_lost = 1; #0.5;
    chk("R2 immediate off", int'(drive_out), 0);
    step(1); supply_lost = 0; #0.5;
    chk("R2 state back to off", int'(drive_out), 0);
    step(1);
    chk("R2 on again after supply returns", int'(drive_out), 1);

    // Overcurrent blanking and latch-off
    cfg_blank = 4; cfg_latch_mode = 1; cmd_on = 0; step(1);
    cmd_on = 1; flt_ocur = 1; step(1);
    chk("R7 on during inrush", int'(drive_out), 1);
    step(3);
    chk("R7 overcurrent blanked", int'(sticky_status), 0);
    step(1);
    chk("R7 still on at window end", int'(drive_out), 1);
    step(1);
    chk("R4 off after fault", int'(drive_out), 0);
    chk("R4 latched", int'(latched_off), 1);
    chk("R3 overcurrent bit", int'(sticky_status), 2);
    chk("R9 overcurrent count", int'(cnt_ocur), 1);
    flt_ocur = 0; step(5);
    chk("R4 latch holds", int'(latched_off), 1);
    chk("R3 bit survives recovery", int'(sticky_status), 2);
    fault_clear = 1; step(1); fault_clear = 0;
    chk("R9 clear status", int'(sticky_status), 0);
    chk("R9 clear counter", int'(cnt_ocur), 0);
    chk("R4 unlatched after clear", int'(latched_off), 0);
    step(1);
    chk("R4 on after clear", int'(drive_out), 1);

    // Retry with cooldown, then escalation
    cfg_latch_mode = 0; cfg_blank = 0; cfg_max_retry = 2; cfg_cooldown = 3;
    flt_temp = 1; step(1);
    chk("R5 off after thermal fault", int'(drive_out), 0);
    step(3);
    chk("R5 still cooling", int'(drive_out), 0);
    step(1);
    chk("R5 retry turns on", int'(drive_out), 1);
    step(10);
    chk("R6 latched after retries", int'(latched_off), 1);
    chk("R6 thermal count", int'(cnt_temp), 3);

    // Open-load ignored while off, then blanked after turn-on
    flt_temp = 0; fault_clear = 1; step(1); fault_clear = 0;
    cmd_on = 0; step(2); flt_open = 1; step(5);
    chk("R8 open ignored when off", int'(sticky_status), 0);
    chk("R8 open counter when off", int'(cnt_open), 0);
    cfg_blank = 3; cmd_on = 1; step(1);
    step(2);
    chk("R8 open blanked", int'(sticky_status), 0);
    step(1);
    chk("R8 open blanked at window end", int'(sticky_status), 0);
    step(1);
    chk("R8 open qualified", int'(sticky_status), 1);
    chk("R8 open drives off", int'(drive_out), 0);
    flt_open = 0;

    // Saturation of a counter
    fault_clear = 1; step(1); fault_clear = 0;
    cfg_max_retry = 15; cfg_cooldown = 0; cfg_blank = 0; flt_temp = 1;
    step(50);
    chk("R9 saturated count", int'(cnt_temp), CMAXI);
    chk("R6 latched after budget", int'(latched_off), 1);

    // Clear on the same edge as a fault
    flt_temp = 0; fault_clear = 1; step(1); fault_clear = 0;
    cfg_latch_mode = 1; step(1);
    flt_temp = 1; fault_clear = 1; step(1);
    fault_clear = 0; flt_temp = 0;
    chk("R9 hit wins over clear bit", int'(sticky_status), 4);
    chk("R9 hit wins over clear count", int'(cnt_temp), 1);
    chk("R4 latched on hit", int'(latched_off), 1);
    step(2);
    chk("R4 stays latched", int'(latched_off), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule